// File: doc/BRIEF.md
# Single-Wire ROM Command Layer

This block is the identity and addressing stage of a slave device on a single-wire bus. A lower layer turns line activity into three kinds of event: a received-bit strobe with the bit the master wrote, a read-slot strobe that consumes the bit this layer presents, and a bus-reset indication. This layer sits on top of those events. It holds a 64-bit identity made of a family code, a serial number and a CRC byte, and decodes the four ROM function commands. When a command finishes successfully, it raises a `selected` output that hands the bus to the memory command layer.

The CRC byte is computed from the parameters when the design is elaborated. Because the line is open drain, the presented bit is a release level: a 1 leaves the line alone and a 0 pulls it low. Several devices can therefore share one line, and the line carries the AND of their bits. The search command uses this property to let a master find every device on the line, one device per pass.

Top module: `owr_rom_layer`

## Requirements
- R1: The identity is 64 bits and is sent bit 0 first. Bits 7:0 hold the family code (parameter, default 02h), bits 55:8 hold the 48-bit serial number, and bits 63:56 hold the CRC byte.
- R2: The CRC byte is the result of the generator x^8 + x^5 + x^4 + 1 after identity bits 0 to 55 are shifted in least significant first, with the register starting at zero.
- R3: Feeding all 64 identity bits, including the CRC byte, through that generator leaves it at zero.
- R4: After a bus reset, the first 8 received bits form a command byte, least significant bit first. Read (33h) presents identity bits 0 to 63 on 64 read slots, and `selected_o` rises only after the 64th slot.
- R5: Match (55h) compares the next 64 received bits with the identity. If all agree, `selected_o` rises. On any difference the device releases the line and ignores all traffic until a bus reset.
- R6: Skip (CCh) raises `selected_o` right after the 8th command bit, with no identity transfer.
- R7: Search (F0h) takes three slots per identity bit: a read slot presenting the bit, a read slot presenting its complement, then a received bit with the master's choice. A choice that differs from the device's bit drops the device until a bus reset. If the device survives all 64 bits, `selected_o` rises.
- R8: `tx_bit_o` is 1 (line released) whenever the layer is not presenting an identity bit, so the outputs of several devices combine on the line as a wired AND.
- R9: After `rst`, `selected_o` is 0, `tx_bit_o` is 1, and the layer waits for a command byte.
- R10: `bus_rst_i` at any time clears `selected_o` on the next cycle and returns the layer to waiting for a command byte.
- R11: A command byte other than 33h, 55h, CCh and F0h leaves the device unselected and released until a bus reset.
- R12: Once `selected_o` is high, further received bits and read slots leave it high until a bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | One-cycle bus-reset indication from the bit layer |
| rx_stb_i | input | 1 | One-cycle strobe: the master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit, valid with `rx_stb_i` |
| tx_stb_i | input | 1 | One-cycle strobe: a read slot consumed `tx_bit_o` |
| tx_bit_o | output | 1 | Bit presented for the next read slot; 1 means released |
| selected_o | output | 1 | Device addressed; memory command layer owns the bus |

## Verification
The bench builds two instances that share one wired-AND line. Their serial numbers differ only in serial bit 20, which is identity bit 28, so their CRC bytes differ as well. This brings within reach the search slot where the two devices collide: one pass follows each device, and the other device must drop out exactly at bit 28. Both instances keep the default family code 02h. A strobe gate lets the second device sit out single-device tests and join for the collision cases.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

    localparam int FAM_BITS = 8;
    localparam int SER_BITS = 48;
    localparam int CRC_BITS = 8;
    localparam int ID_BITS  = FAM_BITS + SER_BITS + CRC_BITS;
    localparam int CMD_BITS = 8;
    localparam int IDX_W    = $clog2(ID_BITS);

    localparam logic [CMD_BITS-1:0] CMD_READ   = 8'h33;
    localparam logic [CMD_BITS-1:0] CMD_MATCH  = 8'h55;
    localparam logic [CMD_BITS-1:0] CMD_SKIP   = 8'hCC;
    localparam logic [CMD_BITS-1:0] CMD_SEARCH = 8'hF0;

    // x^8 + x^5 + x^4 + 1 in shift-right (reflected) form
    localparam logic [CRC_BITS-1:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SBIT,
        ST_SCMP,
        ST_SDIR,
        ST_SEL,
        ST_IDLE
    } rom_state_e;

    typedef struct packed {
        logic [CRC_BITS-1:0] crc;
        logic [SER_BITS-1:0] serial;
        logic [FAM_BITS-1:0] family;
    } rom_id_t;

    function automatic logic [CRC_BITS-1:0] crc_step(input logic [CRC_BITS-1:0] c,
                                                     input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
    endfunction

    function automatic logic [CRC_BITS-1:0] crc_over(input logic [FAM_BITS+SER_BITS-1:0] d);
        logic [CRC_BITS-1:0] c;
        c = '0;
        for (int i = 0; i < FAM_BITS + SER_BITS; i++) begin
            c = crc_step(c, d[i]);
        end
        crc_over = c;
    endfunction

endpackage

// File: rtl/owr_id_rom.sv
module owr_id_rom
    import owr_rom_pkg::*;
#(
    parameter logic [FAM_BITS-1:0] FAMILY_CODE = 8'h02,
    parameter logic [SER_BITS-1:0] SERIAL_NUM  = 48'h0000_1F2E_3D4C
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             id_bit_o
);

    localparam rom_id_t ID_REC = '{
        crc:    crc_over({SERIAL_NUM, FAMILY_CODE}),
        serial: SERIAL_NUM,
        family: FAMILY_CODE
    };
    localparam logic [ID_BITS-1:0] ID_VEC = ID_REC;

    assign id_bit_o = ID_VEC[idx_i];

endmodule

// File: rtl/owr_bit_ctr.sv
module owr_bit_ctr #(
    parameter int LIMIT = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     inc_i,
    output logic [$clog2(LIMIT)-1:0] idx_o,
    output logic                     last_o
);

    localparam int W = $clog2(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign idx_o  = cnt;
    assign last_o = (cnt == W'(LIMIT - 1));

    AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> !last_o); // R4

endmodule

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         stb_i,
    input  logic         bit_i,
    output logic         done_o,
    output logic [W-1:0] byte_o
);

    localparam int CW = $clog2(W);

    logic [W-2:0]  sh;
    logic [CW-1:0] n;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sh <= '0;
            n  <= '0;
        end else if (stb_i) begin
            sh <= {bit_i, sh[W-2:1]};
            n  <= n + 1'b1;
        end
    end

    assign done_o = stb_i && !clr_i && (n == CW'(W - 1));
    assign byte_o = {bit_i, sh};

endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
    import owr_rom_pkg::*;
#(
    parameter logic [FAM_BITS-1:0] FAMILY_CODE = 8'h02,
    parameter logic [SER_BITS-1:0] SERIAL_NUM  = 48'h0000_1F2E_3D4C
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rst_i,
    input  logic rx_stb_i,
    input  logic rx_bit_i,
    input  logic tx_stb_i,
    output logic tx_bit_o,
    output logic selected_o
);

    rom_state_e            state, nxt;
    logic [IDX_W-1:0]      idx;
    logic                  last, id_bit;
    logic                  ctr_inc, ctr_clr;
    logic                  cmd_done, cmd_clr, cmd_stb;
    logic [CMD_BITS-1:0]   cmd_byte;

    owr_id_rom #(
        .FAMILY_CODE (FAMILY_CODE),
        .SERIAL_NUM  (SERIAL_NUM)
    ) u_id (
        .idx_i    (idx),
        .id_bit_o (id_bit)
    );

    assign ctr_clr = bus_rst_i || (state == ST_CMD);

    owr_bit_ctr #(.LIMIT(ID_BITS)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ctr_clr),
        .inc_i  (ctr_inc),
        .idx_o  (idx),
        .last_o (last)
    );

    assign cmd_clr = bus_rst_i || (state != ST_CMD);
    assign cmd_stb = rx_stb_i && (state == ST_CMD);

    owr_cmd_shift #(.W(CMD_BITS)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cmd_clr),
        .stb_i  (cmd_stb),
        .bit_i  (rx_bit_i),
        .done_o (cmd_done),
        .byte_o (cmd_byte)
    );

    always_comb begin
        nxt     = state;
        ctr_inc = 1'b0;
        unique case (state)
            ST_CMD: begin
                if (cmd_done) begin
                    if (cmd_byte == CMD_READ)        nxt = ST_READ;
                    else if (cmd_byte == CMD_MATCH)  nxt = ST_MATCH;
                    else if (cmd_byte == CMD_SKIP)   nxt = ST_SEL;
                    else if (cmd_byte == CMD_SEARCH) nxt = ST_SBIT;
                    else                             nxt = ST_IDLE;
                end
            end
            ST_READ: begin
                if (tx_stb_i) begin
                    if (last) nxt = ST_SEL;
                    else      ctr_inc = 1'b1;
                end
            end
            ST_MATCH: begin
                if (rx_stb_i) begin
                    if (rx_bit_i != id_bit) nxt = ST_IDLE;
                    else if (last)          nxt = ST_SEL;
                    else                    ctr_inc = 1'b1;
                end
            end
            ST_SBIT: if (tx_stb_i) nxt = ST_SCMP;
            ST_SCMP: if (tx_stb_i) nxt = ST_SDIR;
            ST_SDIR: begin
                if (rx_stb_i) begin
                    if (rx_bit_i != id_bit) begin
                        nxt = ST_IDLE;
                    end else if (last) begin
                        nxt = ST_SEL;
                    end else begin
                        ctr_inc = 1'b1;
                        nxt     = ST_SBIT;
                    end
                end
            end
            default: ;
        endcase
        if (bus_rst_i) nxt = ST_CMD;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_CMD;
        else     state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_READ, ST_SBIT: tx_bit_o = id_bit;
            ST_SCMP:          tx_bit_o = ~id_bit;
            default:          tx_bit_o = 1'b1;
        endcase
    end

    assign selected_o = (state == ST_SEL);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!selected_o && tx_bit_o)); // R9

    AST_BUSRST_DESELECT: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> !selected_o); // R10

    AST_SEL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (selected_o && !bus_rst_i) |=> selected_o); // R12

    AST_MATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MATCH && rx_stb_i && rx_bit_i != id_bit && !bus_rst_i)
            |=> (!selected_o && tx_bit_o)); // R5

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !bus_rst_i) |=> (state == ST_IDLE && tx_bit_o)); // R11

    AST_SEL_RELEASED: assert property (@(posedge clk) disable iff (rst)
        selected_o |-> tx_bit_o); // R8

endmodule

// File: tb/tb_owr_rom_layer.sv
`timescale 1ns/1ps
module tb_owr_rom_layer;

    localparam logic [47:0] SER_A = 48'h5A1C_3390_7E42;
    localparam logic [47:0] SER_B = SER_A ^ 48'h0000_0010_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rst = 1'b0;
    logic rx_stb = 1'b0;
    logic rx_bit = 1'b0;
    logic tx_stb = 1'b0;
    logic b_join = 1'b0;
    logic txa, txb, sela, selb, line;

    always #4 clk = ~clk;

    owr_rom_layer #(.SERIAL_NUM(SER_A)) dut (
        .clk(clk), .rst(rst), .bus_rst_i(bus_rst),
        .rx_stb_i(rx_stb), .rx_bit_i(rx_bit), .tx_stb_i(tx_stb),
        .tx_bit_o(txa), .selected_o(sela));

    owr_rom_layer #(.SERIAL_NUM(SER_B)) dut_b (
        .clk(clk), .rst(rst), .bus_rst_i(bus_rst),
        .rx_stb_i(rx_stb & b_join), .rx_bit_i(rx_bit), .tx_stb_i(tx_stb & b_join),
        .tx_bit_o(txb), .selected_o(selb));

    assign line = txa & txb;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic exp_q[$];
    string tag_q[$];
    logic [63:0] cap = '0;

    // generator x^8+x^5+x^4+1, LSB first: feedback enters bit 7, taps at bits 3 and 2
    function automatic logic [7:0] ref_crc(input logic [63:0] d, input int n);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic fb;
            fb = d[i] ^ r[0];
            r = {fb, r[7:1]};
            r[3] = r[3] ^ fb;
            r[2] = r[2] ^ fb;
        end
        return r;
    endfunction

    function automatic logic [63:0] id_of(input logic [47:0] s);
        logic [63:0] base;
        base = {8'h00, s, 8'h02};
        return {ref_crc(base, 56), s, 8'h02};
    endfunction

    logic [63:0] ida, idb;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // monitor: pops the expected bit of every read slot
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (tx_stb) begin
                cap = {line, cap[63:1]};
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected slot", 64'(line), 64'h1);
                end else begin
                    logic e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(line === e, t, 64'(line), 64'(e));
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk); rx_stb = 1'b1; rx_bit = b;
        @(negedge clk); rx_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic read_slot(input logic e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk); tx_stb = 1'b1;
        @(negedge clk); tx_stb = 1'b0;
    endtask

    task automatic pulse_bus_rst();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic search_pass(input logic [63:0] win, input logic [63:0] other);
        bit alive;
        alive = 1;
        for (int i = 0; i < 64; i++) begin
            logic e1, e2;
            e1 = win[i] & (alive ? other[i] : 1'b1);
            e2 = ~win[i] & (alive ? ~other[i] : 1'b1);
            read_slot(e1, alive ? "R8 search wired bit" : "R7 search bit");
            read_slot(e2, alive ? "R8 search wired complement" : "R7 search complement");
            send_bit(win[i]);
            if (alive && other[i] != win[i]) alive = 0;
        end
    endtask

    initial begin
        ida = id_of(SER_A);
        idb = id_of(SER_B);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sela == 1'b0, "R9 selected after reset", 64'(sela), 64'h0);
        check(txa == 1'b1, "R9 released after reset", 64'(txa), 64'h1);

        // Read, single device
        pulse_bus_rst();
        send_byte(8'h33);
        for (int i = 0; i < 63; i++)
            read_slot(ida[i], i < 8 ? "R1 family bit" : (i < 56 ? "R1 serial bit" : "R2 crc bit"));
        check(sela == 1'b0, "R4 selected before last slot", 64'(sela), 64'h0);
        read_slot(ida[63], "R2 crc bit");
        check(sela == 1'b1, "R4 selected after 64 slots", 64'(sela), 64'h1);
        check(ref_crc(cap, 64) == 8'h00, "R3 residue", 64'(ref_crc(cap, 64)), 64'h0);
        check(cap[63:56] == ref_crc({8'h00, SER_A, 8'h02}, 56), "R2 crc byte",
              64'(cap[63:56]), 64'(ref_crc({8'h00, SER_A, 8'h02}, 56)));
        check(selb == 1'b0, "R4 absent device unselected", 64'(selb), 64'h0);
        send_byte(8'h55);
        read_slot(1'b1, "R8 released while selected");
        check(sela == 1'b1, "R12 stays selected", 64'(sela), 64'h1);

        // Match, correct
        pulse_bus_rst();
        check(sela == 1'b0, "R10 bus reset clears", 64'(sela), 64'h0);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(ida[i]);
        check(sela == 1'b1, "R5 match selects", 64'(sela), 64'h1);

        // Match, wrong bit 40
        pulse_bus_rst();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(i == 40 ? ~ida[i] : ida[i]);
        check(sela == 1'b0, "R5 mismatch not selected", 64'(sela), 64'h0);
        for (int i = 0; i < 4; i++) read_slot(1'b1, "R5 released after mismatch");
        send_byte(8'hCC);
        check(sela == 1'b0, "R5 idle until bus reset", 64'(sela), 64'h0);

        // bus reset mid-match
        pulse_bus_rst();
        send_byte(8'h55);
        for (int i = 0; i < 20; i++) send_bit(ida[i]);
        pulse_bus_rst();
        send_byte(8'hCC);
        check(sela == 1'b1, "R10 mid-command bus reset restarts", 64'(sela), 64'h1);

        // Skip timing
        pulse_bus_rst();
        for (int i = 0; i < 7; i++) send_bit(1'(8'hCC >> i));
        check(sela == 1'b0, "R6 not selected before 8th bit", 64'(sela), 64'h0);
        send_bit(1'b1);
        check(sela == 1'b1, "R6 skip selects", 64'(sela), 64'h1);

        // Unknown command
        pulse_bus_rst();
        send_byte(8'hA5);
        check(sela == 1'b0, "R11 unknown code", 64'(sela), 64'h0);
        send_byte(8'h33);
        for (int i = 0; i < 4; i++) read_slot(1'b1, "R11 released after unknown");
        send_byte(8'hCC);
        check(sela == 1'b0, "R11 ignores later commands", 64'(sela), 64'h0);
        pulse_bus_rst();
        send_byte(8'hCC);
        check(sela == 1'b1, "R11 recovers on bus reset", 64'(sela), 64'h1);

        // Search, two devices, follow A then B
        b_join = 1'b1;
        pulse_bus_rst();
        send_byte(8'hF0);
        search_pass(ida, idb);
        check(sela == 1'b1, "R7 winner selected", 64'(sela), 64'h1);
        check(selb == 1'b0, "R7 loser dropped", 64'(selb), 64'h0);
        pulse_bus_rst();
        send_byte(8'hF0);
        search_pass(idb, ida);
        check(selb == 1'b1, "R7 winner selected", 64'(selb), 64'h1);
        check(sela == 1'b0, "R7 loser dropped", 64'(sela), 64'h0);

        // Read with both present: wired AND collision
        pulse_bus_rst();
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) read_slot(ida[i] & idb[i], "R8 read collision");
        check(sela && selb, "R4 both selected after read", {62'h0, sela, selb}, 64'h3);

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R4 watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule